// File: doc/BRIEF.md
# Protected Standby Mode Register

This block holds the 8-bit control byte that chooses the processor's power state. Only two bits of it can change: a stop select bit and a halt select bit. A special, self-checking write path is the only way to change them. That path carries a value byte and a check byte. The update happens only when every bit of the check byte is the inverse of the matching value bit. A pair that fails this test leaves the register as it was. It also raises a one-cycle operand-error interrupt request and captures the address of the instruction that issued the write, so that software sees where the stray write came from.

Ordinary bus writes to the register's address are dropped without any side effect. Bus reads of that address return the register at any time. The two select bits are decoded into four one-hot mode indications for the standby sequencer: run, HALT, STOP and IDLE. There is also a sticky configuration warning. It is set when STOP is selected while an external clock is in use but the external-clock enable has not yet been set.

Top module: `pwrmode_top`

## Requirements
- R1: A dedicated write (`prot_wr_i` high) with `prot_data_i == ~prot_chk_i` loads bits [1:0] of `prot_data_i` into register bits [1:0] (bit 1 = stop select, bit 0 = halt select) at the clock edge where the strobe is sampled. `operr_irq_o` stays low after that edge.
- R2: A dedicated write whose two bytes are not bitwise complements leaves the register unchanged. `operr_irq_o` is high for exactly the one cycle after that edge.
- R3: On such a faulting write, `err_pc_o` captures the `prot_pc_i` that came with it. A valid write leaves `err_pc_o` unchanged.
- R4: Generic writes (`bus_wr_i`) to address 0xFFC0 change no register bit and raise no interrupt, whatever their timing.
- R5: A read (`bus_rd_i` high, `bus_wr_i` low) at address 0xFFC0 returns the full register byte on `rd_data_o` in the next cycle. A read at any other address returns 0x00.
- R6: Synchronous reset sets the register to 0x30, `mode_o` to run, and `operr_irq_o`, `err_pc_o` and `cfg_viol_o` to zero.
- R7: Register bits [7:2] always read as 001100, whatever value is written.
- R8: `mode_o` is one-hot and follows the register bits {stop, halt}: 00 gives bit 0 (run), 01 gives bit 1 (HALT), 10 gives bit 2 (STOP), 11 gives bit 3 (IDLE). It changes at the same edge as the register.
- R9: A valid write that selects 10 while `ext_clk_use_i` = 1 and `ext_clk_en_i` = 0 still completes, and it sets `cfg_viol_o`. The flag then stays set until reset.
- R10: When a dedicated write and a generic write are both high in the same cycle, the dedicated write is handled exactly as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_wr_i | input | 1 | Dedicated write strobe |
| prot_data_i | input | 8 | Dedicated write value byte |
| prot_chk_i | input | 8 | Dedicated write check byte (must be ~value) |
| prot_pc_i | input | PC_W | Address of the instruction issuing the dedicated write |
| bus_wr_i | input | 1 | Generic bus write strobe (always discarded) |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Bus address |
| ext_clk_use_i | input | 1 | External clock is in use |
| ext_clk_en_i | input | 1 | External-clock enable bit of the oscillator setup |
| ctl_q_o | output | 8 | Current register byte |
| mode_o | output | 4 | One-hot mode: [0] run, [1] HALT, [2] STOP, [3] IDLE |
| operr_irq_o | output | 1 | One-cycle operand-error interrupt request |
| err_pc_o | output | PC_W | Address of the last faulting dedicated write |
| rd_data_o | output | 8 | Registered read data |
| cfg_viol_o | output | 1 | Sticky STOP-with-external-clock warning |

## Verification
A corrupted stop or halt bit shows up in the very next cycle in two places: `ctl_q_o` and the one-hot `mode_o`. It also shows in a register read one cycle after the read is issued. A wrong complement decision shows one cycle after the strobe, as either a register change with no interrupt or an interrupt with the register unchanged. An error address that was not captured, or was overwritten by a valid write, shows on `err_pc_o` from that same cycle on. A warning flag that was set in error, or that clears by itself, is visible on `cfg_viol_o` at any later cycle before reset.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  localparam int SEL_W  = 2;
  localparam int MODE_N = 1 << SEL_W;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-SEL_W-1:0] FIXED_HI = 6'b001100;

  typedef enum logic [SEL_W-1:0] {
    MODE_RUN  = 2'b00,
    MODE_HALT = 2'b01,
    MODE_STOP = 2'b10,
    MODE_IDLE = 2'b11
  } mode_sel_e;
endpackage

// File: rtl/pwrmode_chk.sv
module pwrmode_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] chk_i,
  output logic         match_o
);
  // value and check byte must be exact bitwise inverses
  assign match_o = ((data_i ^ chk_i) == {W{1'b1}});
endmodule

// File: rtl/pwrmode_dec.sv
module pwrmode_dec
  import pwrmode_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  output logic [MODE_N-1:0] onehot_o
);
  for (genvar g = 0; g < MODE_N; g++) begin : g_line
    assign onehot_o[g] = (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/pwrmode_top.sv
module pwrmode_top
  import pwrmode_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFC0,
  parameter int              PC_W     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_wr_i,
  input  logic [7:0]        prot_data_i,
  input  logic [7:0]        prot_chk_i,
  input  logic [PC_W-1:0]   prot_pc_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              ext_clk_use_i,
  input  logic              ext_clk_en_i,
  output logic [7:0]        ctl_q_o,
  output logic [3:0]        mode_o,
  output logic              operr_irq_o,
  output logic [PC_W-1:0]   err_pc_o,
  output logic [7:0]        rd_data_o,
  output logic              cfg_viol_o
);
  logic             match;
  logic             take;
  logic             fault;
  logic             risky_stop;
  logic             rd_hit;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_n;
  logic [MODE_N-1:0] mode_n;

  pwrmode_chk #(.W(BYTE_W)) u_chk (
    .data_i  (prot_data_i),
    .chk_i   (prot_chk_i),
    .match_o (match)
  );

  // only the dedicated path can write; generic writes have no enable at all
  assign take  = prot_wr_i & match;
  assign fault = prot_wr_i & ~match;
  assign sel_n = take ? prot_data_i[SEL_W-1:0] : sel_q;

  assign risky_stop = take && (mode_sel_e'(prot_data_i[SEL_W-1:0]) == MODE_STOP)
                      && ext_clk_use_i && !ext_clk_en_i;

  // a cycle that both reads and writes is a write cycle, so it returns no data
  assign rd_hit = bus_rd_i && !bus_wr_i && (bus_addr_i == REG_ADDR);

  pwrmode_dec u_dec (
    .sel_i    (sel_n),
    .onehot_o (mode_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= MODE_RUN;
      mode_o      <= 4'b0001;
      operr_irq_o <= 1'b0;
      err_pc_o    <= '0;
      cfg_viol_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      sel_q       <= sel_n;
      mode_o      <= mode_n;
      operr_irq_o <= fault;
      if (fault)      err_pc_o   <= prot_pc_i;
      if (risky_stop) cfg_viol_o <= 1'b1;
      rd_data_o   <= rd_hit ? {FIXED_HI, sel_q} : '0;
    end
  end

  assign ctl_q_o = {FIXED_HI, sel_q};
endmodule

// File: rtl/pwrmode_top_sva.sv
module pwrmode_top_sva #(
  parameter int PC_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            prot_wr_i,
  input logic [7:0]      prot_data_i,
  input logic [7:0]      prot_chk_i,
  input logic [PC_W-1:0] prot_pc_i,
  input logic [7:0]      ctl_q_o,
  input logic [3:0]      mode_o,
  input logic            operr_irq_o,
  input logic [PC_W-1:0] err_pc_o,
  input logic            cfg_viol_o
);
  a_r1_good_write: assert property (@(posedge clk) disable iff (rst)
    (prot_wr_i && (prot_data_i == ~prot_chk_i))
      |=> (ctl_q_o[1:0] == $past(prot_data_i[1:0])) && !operr_irq_o);

  a_r2_bad_write: assert property (@(posedge clk) disable iff (rst)
    (prot_wr_i && (prot_data_i != ~prot_chk_i))
      |=> operr_irq_o && $stable(ctl_q_o));

  a_r3_err_pc: assert property (@(posedge clk) disable iff (rst)
    (prot_wr_i && (prot_data_i != ~prot_chk_i))
      |=> (err_pc_o == $past(prot_pc_i)));

  a_r3_pc_kept: assert property (@(posedge clk) disable iff (rst)
    (prot_wr_i && (prot_data_i == ~prot_chk_i)) |=> $stable(err_pc_o));

  a_r4_no_side_write: assert property (@(posedge clk) disable iff (rst)
    !prot_wr_i |=> $stable(ctl_q_o) && !operr_irq_o);

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    ctl_q_o[7:2] == 6'b001100);

  a_r8_mode_follows: assert property (@(posedge clk) disable iff (rst)
    ($countones(mode_o) == 1) && mode_o[ctl_q_o[1:0]]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_viol_o |=> cfg_viol_o);
endmodule

bind pwrmode_top pwrmode_top_sva #(.PC_W(PC_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .prot_wr_i   (prot_wr_i),
  .prot_data_i (prot_data_i),
  .prot_chk_i  (prot_chk_i),
  .prot_pc_i   (prot_pc_i),
  .ctl_q_o     (ctl_q_o),
  .mode_o      (mode_o),
  .operr_irq_o (operr_irq_o),
  .err_pc_o    (err_pc_o),
  .cfg_viol_o  (cfg_viol_o)
);

// File: tb/sim_pwrmode_top.sv
module sim_pwrmode_top;
  localparam int ADDR_W = 16;
  localparam int PC_W   = 24;
  localparam int NVEC   = 8;
  localparam logic [ADDR_W-1:0] A_REG = 16'hFFC0;

  // entry = {value byte, check byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h01FE, 16'h02FD, 16'h03FC, 16'h00FF,
    16'h01FF, 16'hFE01, 16'h0303, 16'h817E
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_wr_i = 1'b0;
  logic [7:0] prot_data_i = '0;
  logic [7:0] prot_chk_i = '0;
  logic [PC_W-1:0] prot_pc_i = '0;
  logic bus_wr_i = 1'b0;
  logic bus_rd_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic ext_clk_use_i = 1'b0;
  logic ext_clk_en_i = 1'b0;
  logic [7:0] ctl_q_o;
  logic [3:0] mode_o;
  logic operr_irq_o;
  logic [PC_W-1:0] err_pc_o;
  logic [7:0] rd_data_o;
  logic cfg_viol_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwrmode_top #(.ADDR_W(ADDR_W), .REG_ADDR(A_REG), .PC_W(PC_W)) u0 (
    .clk(clk), .rst(rst),
    .prot_wr_i(prot_wr_i), .prot_data_i(prot_data_i), .prot_chk_i(prot_chk_i),
    .prot_pc_i(prot_pc_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .ext_clk_use_i(ext_clk_use_i), .ext_clk_en_i(ext_clk_en_i),
    .ctl_q_o(ctl_q_o), .mode_o(mode_o), .operr_irq_o(operr_irq_o),
    .err_pc_o(err_pc_o), .rd_data_o(rd_data_o), .cfg_viol_o(cfg_viol_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] onehot(input logic [1:0] s);
    return 4'b0001 << s;
  endfunction

  // drive one cycle at the falling edge, then sample 1 ns after the rising edge
  task automatic cycle(input logic pw, input logic [7:0] d, input logic [7:0] c,
                       input logic [PC_W-1:0] pc, input logic bw, input logic br,
                       input logic [ADDR_W-1:0] a);
    @(negedge clk);
    prot_wr_i = pw; prot_data_i = d; prot_chk_i = c; prot_pc_i = pc;
    bus_wr_i = bw; bus_rd_i = br; bus_addr_i = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    prot_wr_i = 1'b0; bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] m_sel;
    logic [PC_W-1:0] m_pc;

    do_reset();
    // R6 reset state
    check("R6 reg", ctl_q_o, 8'h30);
    check("R6 mode", mode_o, 4'b0001);
    check("R6 irq", operr_irq_o, 0);
    check("R6 err_pc", err_pc_o, 0);
    check("R6 viol", cfg_viol_o, 0);

    m_sel = 2'b00;
    m_pc  = '0;
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] d;
      logic [7:0] c;
      logic ok;
      logic [PC_W-1:0] pc;
      d  = VEC[i][15:8];
      c  = VEC[i][7:0];
      pc = PC_W'(24'h001000 + i * 4);
      ok = (d == ~c);
      cycle(1'b1, d, c, pc, 1'b0, 1'b0, '0);
      if (ok) m_sel = d[1:0];
      else    m_pc  = pc;
      check(ok ? "R1 reg" : "R2 reg", ctl_q_o, {6'b001100, m_sel});
      check("R7 fixed", ctl_q_o[7:2], 6'b001100);
      check("R8 mode", mode_o, onehot(m_sel));
      check(ok ? "R1 irq" : "R2 irq", operr_irq_o, !ok);
      check("R3 err_pc", err_pc_o, m_pc);
    end

    // R2 pulse lasts exactly one cycle
    cycle(1'b1, 8'h12, 8'h34, 24'h00ABCD, 1'b0, 1'b0, '0);
    check("R2 pulse on", operr_irq_o, 1);
    check("R3 latch", err_pc_o, 24'h00ABCD);
    cycle(1'b0, 8'h00, 8'h00, 24'h0, 1'b0, 1'b0, '0);
    check("R2 pulse off", operr_irq_o, 0);
    check("R3 hold", err_pc_o, 24'h00ABCD);

    // R4 generic writes ignored; then R5 read back
    cycle(1'b0, 8'h00, 8'hFF, 24'h0, 1'b1, 1'b0, A_REG);
    cycle(1'b0, 8'h02, 8'hFD, 24'h0, 1'b1, 1'b0, A_REG);
    check("R4 reg", ctl_q_o, 8'h31);
    check("R4 mode", mode_o, 4'b0010);
    check("R4 irq", operr_irq_o, 0);
    cycle(1'b0, 8'h00, 8'h00, 24'h0, 1'b0, 1'b1, A_REG);
    check("R5 read hit", rd_data_o, 8'h31);
    cycle(1'b0, 8'h00, 8'h00, 24'h0, 1'b0, 1'b1, 16'hFFC1);
    check("R5 read miss", rd_data_o, 8'h00);

    // R10 dedicated wins over simultaneous generic write
    cycle(1'b1, 8'h03, 8'hFC, 24'h000200, 1'b1, 1'b0, A_REG);
    check("R10 reg", ctl_q_o, 8'h33);
    check("R10 mode", mode_o, 4'b1000);
    cycle(1'b1, 8'h00, 8'h00, 24'h000204, 1'b1, 1'b0, A_REG);
    check("R10 irq", operr_irq_o, 1);
    check("R10 hold", ctl_q_o, 8'h33);

    // R9 STOP with external clock enabled: no warning
    @(negedge clk); ext_clk_use_i = 1'b1; ext_clk_en_i = 1'b1;
    cycle(1'b1, 8'h02, 8'hFD, 24'h0, 1'b0, 1'b0, '0);
    check("R9 safe stop", cfg_viol_o, 0);
    check("R9 safe reg", ctl_q_o, 8'h32);
    // R9 STOP with external clock not enabled: write still done, flag set
    @(negedge clk); ext_clk_en_i = 1'b0;
    cycle(1'b1, 8'h00, 8'hFF, 24'h0, 1'b0, 1'b0, '0);
    cycle(1'b1, 8'h02, 8'hFD, 24'h0, 1'b0, 1'b0, '0);
    check("R9 flag", cfg_viol_o, 1);
    check("R9 reg", ctl_q_o, 8'h32);
    check("R9 mode", mode_o, 4'b0100);
    cycle(1'b1, 8'h00, 8'hFF, 24'h0, 1'b0, 1'b0, '0);
    check("R9 sticky", cfg_viol_o, 1);
    @(negedge clk); ext_clk_use_i = 1'b0;
    do_reset();
    check("R9 cleared", cfg_viol_o, 0);
    check("R6 reg again", ctl_q_o, 8'h30);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule